// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a word-wide flash array and turns a stream of bus writes into decoded operations. Every write carries a 17-bit word address and a 16-bit data value. The decoder only accepts a command after a two-write unlock preamble at two fixed addresses. The operations that destroy data (chip erase, sector erase and boot-lockout enable) also need a second unlock preamble. When a sequence completes, the block issues a one-cycle strobe. The strobe carries the operation code, the target address, the program data and the sector field. The array controller acts on that strobe.

The block also keeps a product-identification flag. While the flag is set, reads of the two lowest word addresses return fixed identification codes instead of array data. The array controller drives a busy input while a program or erase is running. Writes that arrive during busy are dropped and do not move the sequence. The strobe is registered and appears in the cycle after the final write of a sequence. The identification flag follows one cycle after the strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `cmd_valid` is 0, `cmd_op` is 0 and `id_mode` is 0. The next write is treated as the first write of a sequence.
- R2: Command cycles compare only `wr_data[7:0]` with the command code, so the upper byte can hold any value. The data write of a word program still passes all 16 bits to `cmd_data`.
- R3: Word program: AA to 5555, 55 to 2AAA, A0 to 5555, then a write of any data to any address. This gives one strobe with `cmd_op`=1, `cmd_addr` equal to that address and `cmd_data` equal to that data.
- R4: Chip erase: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555. This gives a strobe with `cmd_op`=2.
- R5: Sector erase has the same first five writes as chip erase, then 30 written to any address. This gives `cmd_op`=3, with `cmd_addr` equal to that address and `cmd_sector` equal to its bits [16:12].
- R6: Boot-lockout enable has the same first five writes as chip erase, then 40@5555. This gives `cmd_op`=4.
- R7: Identification entry: AA@5555, 55@2AAA, 90@5555. This gives `cmd_op`=5, and `id_mode` is 1 from the cycle after the strobe.
- R8: Identification exit takes either of two forms. One is AA@5555, 55@2AAA, F0@5555. The other is a single F0 written to any address while no sequence is under way. Both give `cmd_op`=6, and `id_mode` is 0 from the cycle after the strobe.
- R9: A write while `busy` is 1 produces no strobe and does not change the sequence position. After `busy` drops, the sequence continues from where it was.
- R10: A write whose address or code does not fit the current step returns the decoder to the start with no strobe, even if it would fit some other step.
- R11: While `id_mode` is 1, `rd_addr`=0 gives `id_hit`=1 and `id_data`=001F, and `rd_addr`=1 gives `id_hit`=1 and `id_data`=0082. Any other address, or `id_mode` 0, gives `id_hit`=0 and `id_data`=0. These outputs are combinational at the default setting.
- R12: `cmd_valid` is high only in the single cycle after the completing write. `cmd_op` is 0 whenever `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | 17 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Embedded program or erase in progress; writes are dropped |
| rd_addr | input | 17 | Read address for the identification lookup |
| cmd_valid | output | 1 | One-cycle decoded-command strobe |
| cmd_op | output | 3 | Operation: 1 program, 2 chip erase, 3 sector erase, 4 boot lock, 5 ID entry, 6 ID exit |
| cmd_addr | output | 17 | Address of the completing write |
| cmd_data | output | 16 | Data of the completing write |
| cmd_sector | output | 5 | Upper address bits [16:12] of the completing write |
| id_mode | output | 1 | Product-identification mode active |
| id_hit | output | 1 | The read address falls on an identification word while in ID mode |
| id_data | output | 16 | Identification word for `rd_addr` |

## Verification
The bench goes after sequences that share a long common prefix. The three six-write commands differ only in their last write. A decoder that branches too early would give chip erase when boot lock was meant, or would take the sector from the wrong write. Writes during busy are interleaved with writes that would be a mismatch if accepted. A design that lets busy writes through falls back to the start, and the later identification entry then never fires. Wrong-address and wrong-upper-byte writes check that the restart-on-mismatch rule and the low-byte compare hold. The two exit forms and the identification reads check that the mode flag sets and clears, and that a read outside the two code words returns nothing.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

   localparam int CODE_W = 8;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_CHIP   = 3'd2,
      OP_SECT   = 3'd3,
      OP_BOOT   = 3'd4,
      OP_ID_IN  = 3'd5,
      OP_ID_OUT = 3'd6
   } flcmd_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_K1   = 3'd1,
      ST_K2   = 3'd2,
      ST_PRG  = 3'd3,
      ST_X3   = 3'd4,
      ST_X4   = 3'd5,
      ST_X5   = 3'd6
   } flcmd_st_e;

   localparam logic [CODE_W-1:0] KEY_FIRST  = 8'hAA;
   localparam logic [CODE_W-1:0] KEY_SECOND = 8'h55;
   localparam logic [CODE_W-1:0] C_PROG     = 8'hA0;
   localparam logic [CODE_W-1:0] C_EXT      = 8'h80;
   localparam logic [CODE_W-1:0] C_ID_IN    = 8'h90;
   localparam logic [CODE_W-1:0] C_ID_OUT   = 8'hF0;
   localparam logic [CODE_W-1:0] C_CHIP     = 8'h10;
   localparam logic [CODE_W-1:0] C_SECT     = 8'h30;
   localparam logic [CODE_W-1:0] C_BOOT     = 8'h40;

endpackage

// File: rtl/flcmd_seq.sv
module flcmd_seq
   import flcmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int SECT_W = 5,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 17'h05555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = 17'h02AAA
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic              cmd_valid,
   output flcmd_op_e         cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [SECT_W-1:0] cmd_sector
);

   localparam int SECT_LSB = ADDR_W - SECT_W;

   generate
      if (DATA_W < CODE_W) begin : g_bad_data
         $error("flcmd_seq: DATA_W must hold a command code");
      end
      if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
         $error("flcmd_seq: SECT_W out of range");
      end
   endgenerate

   flcmd_st_e         st_q, st_n;
   logic              take;
   logic              at_a, at_b;
   logic [CODE_W-1:0] code;
   logic              fire;
   flcmd_op_e         fire_op;

   assign take = wr_en && !busy;
   assign at_a = (wr_addr == KEY_ADDR_A);
   assign at_b = (wr_addr == KEY_ADDR_B);
   assign code = wr_data[CODE_W-1:0];

   always_comb begin
      st_n    = st_q;
      fire    = 1'b0;
      fire_op = OP_NONE;
      if (take) begin
         st_n = ST_IDLE;
         unique case (st_q)
            ST_IDLE: begin
               if (at_a && code == KEY_FIRST) st_n = ST_K1;
               else if (code == C_ID_OUT) begin
                  fire = 1'b1; fire_op = OP_ID_OUT;
               end
            end
            ST_K1: if (at_b && code == KEY_SECOND) st_n = ST_K2;
            ST_K2: if (at_a) begin
               if (code == C_PROG)        st_n = ST_PRG;
               else if (code == C_EXT)    st_n = ST_X3;
               else if (code == C_ID_IN)  begin fire = 1'b1; fire_op = OP_ID_IN;  end
               else if (code == C_ID_OUT) begin fire = 1'b1; fire_op = OP_ID_OUT; end
            end
            ST_PRG: begin
               fire = 1'b1; fire_op = OP_PROG;
            end
            ST_X3: if (at_a && code == KEY_FIRST) st_n = ST_X4;
            ST_X4: if (at_b && code == KEY_SECOND) st_n = ST_X5;
            ST_X5: begin
               if (code == C_SECT) begin fire = 1'b1; fire_op = OP_SECT; end
               else if (at_a && code == C_CHIP) begin fire = 1'b1; fire_op = OP_CHIP; end
               else if (at_a && code == C_BOOT) begin fire = 1'b1; fire_op = OP_BOOT; end
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_IDLE;
         cmd_valid  <= 1'b0;
         cmd_op     <= OP_NONE;
         cmd_addr   <= '0;
         cmd_data   <= '0;
         cmd_sector <= '0;
      end else begin
         st_q      <= st_n;
         cmd_valid <= fire;
         cmd_op    <= fire_op;
         if (fire) begin
            cmd_addr   <= wr_addr;
            cmd_data   <= wr_data;
            cmd_sector <= wr_addr[SECT_LSB +: SECT_W];
         end
      end
   end

   AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
      (busy || !wr_en) |=> !cmd_valid); // R9
   AST_BUSY_HOLDS_STEP: assert property (@(posedge clk) disable iff (rst)
      (busy || !wr_en) |=> $stable(st_q)); // R9
   AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> st_q == ST_IDLE); // R10
   AST_OP_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid != (cmd_op != OP_NONE)) == 1'b0); // R12

endmodule

// File: rtl/flcmd_idmode.sv
module flcmd_idmode
   import flcmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int RD_REG = 0,
   parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
   parameter logic [DATA_W-1:0] DEV_CODE = 16'h0082
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  flcmd_op_e         cmd_op,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              id_mode,
   output logic              id_hit,
   output logic [DATA_W-1:0] id_data
);

   generate
      if (RD_REG != 0 && RD_REG != 1) begin : g_bad_rdreg
         $error("flcmd_idmode: RD_REG must be 0 or 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) id_mode <= 1'b0;
      else if (cmd_valid && cmd_op == OP_ID_IN)  id_mode <= 1'b1;
      else if (cmd_valid && cmd_op == OP_ID_OUT) id_mode <= 1'b0;
   end

   logic              hit_c;
   logic [DATA_W-1:0] word_c;

   always_comb begin
      hit_c  = 1'b0;
      word_c = '0;
      if (id_mode && rd_addr == '0) begin
         hit_c = 1'b1; word_c = MFR_CODE;
      end else if (id_mode && rd_addr == ADDR_W'(1)) begin
         hit_c = 1'b1; word_c = DEV_CODE;
      end
   end

   generate
      if (RD_REG == 1) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (rst) begin
               id_hit  <= 1'b0;
               id_data <= '0;
            end else begin
               id_hit  <= hit_c;
               id_data <= word_c;
            end
         end
      end else begin : g_rd_comb
         assign id_hit  = hit_c;
         assign id_data = word_c;
      end
   endgenerate

   AST_ID_SET: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_ID_IN) |=> id_mode); // R7
   AST_ID_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_ID_OUT) |=> !id_mode); // R8
   AST_ID_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |=> $stable(id_mode)); // R11

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flcmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int SECT_W = 5,
   parameter int ID_RD_REG = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [SECT_W-1:0] cmd_sector,
   output logic              id_mode,
   output logic              id_hit,
   output logic [DATA_W-1:0] id_data
);

   flcmd_op_e op_w;

   flcmd_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
      .KEY_ADDR_A(ADDR_W'(17'h05555)), .KEY_ADDR_B(ADDR_W'(17'h02AAA))
   ) u_seq (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid),
      .cmd_op(op_w), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .cmd_sector(cmd_sector)
   );

   flcmd_idmode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_REG(ID_RD_REG),
      .MFR_CODE(DATA_W'(16'h001F)), .DEV_CODE(DATA_W'(16'h0082))
   ) u_id (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_w),
      .rd_addr(rd_addr), .id_mode(id_mode), .id_hit(id_hit),
      .id_data(id_data)
   );

   assign cmd_op = op_w;

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!cmd_valid && !id_mode)); // R1

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy = 1'b0;
   logic [16:0] rd_addr = '0;
   logic        cmd_valid;
   logic [2:0]  cmd_op;
   logic [16:0] cmd_addr;
   logic [15:0] cmd_data;
   logic [4:0]  cmd_sector;
   logic        id_mode, id_hit;
   logic [15:0] id_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic        s_v;
   logic [2:0]  s_op;
   logic [16:0] s_addr;
   logic [15:0] s_data;
   logic [4:0]  s_sect;

   always #2 clk = ~clk;

   flash_cmd_decoder u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .cmd_sector(cmd_sector), .id_mode(id_mode),
      .id_hit(id_hit), .id_data(id_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [16:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      s_v = cmd_valid; s_op = cmd_op; s_addr = cmd_addr;
      s_data = cmd_data; s_sect = cmd_sector;
      wr_en = 1'b0;
   endtask

   task automatic idle1();
      @(negedge clk);
   endtask

   task automatic quiet(input string req);
      chk(s_v == 1'b0, req, {31'd0, s_v}, 32'd0);
   endtask

   task automatic unlock(input string req);
      wr(17'h05555, 16'h00AA); quiet(req);
      wr(17'h02AAA, 16'h0055); quiet(req);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(cmd_valid == 1'b0, "R1 valid", {31'd0, cmd_valid}, 0);
      chk(cmd_op == 3'd0, "R1 op", {29'd0, cmd_op}, 0);
      chk(id_mode == 1'b0, "R1 id_mode", {31'd0, id_mode}, 0);
   endtask

   task automatic t_program();
      unlock("R3 prefix");
      wr(17'h05555, 16'h00A0); quiet("R3 prefix");
      wr(17'h1234A, 16'hBEEF);
      chk(s_v && s_op == 3'd1, "R3 op", {29'd0, s_op}, 1);
      chk(s_addr == 17'h1234A, "R3 addr", {15'd0, s_addr}, 32'h1234A);
      chk(s_data == 16'hBEEF, "R3 data", {16'd0, s_data}, 32'hBEEF);
      idle1();
      chk(cmd_valid == 1'b0 && cmd_op == 3'd0, "R12 one cycle",
          {29'd0, cmd_op}, 0);
   endtask

   task automatic t_ext(input logic [16:0] a, input logic [7:0] c);
      unlock("R4 prefix");
      wr(17'h05555, 16'h0080); quiet("R4 prefix");
      unlock("R4 prefix");
      wr(a, {8'h00, c});
   endtask

   task automatic t_erase_lock();
      t_ext(17'h05555, 8'h10);
      chk(s_v && s_op == 3'd2, "R4 chip erase", {29'd0, s_op}, 2);
      t_ext(17'h05123, 8'h30);
      chk(s_v && s_op == 3'd3, "R5 sector op", {29'd0, s_op}, 3);
      chk(s_addr == 17'h05123, "R5 sector addr", {15'd0, s_addr}, 32'h05123);
      chk(s_sect == 5'h05, "R5 sector field", {27'd0, s_sect}, 5);
      t_ext(17'h1F800, 8'h30);
      chk(s_v && s_sect == 5'h1F, "R5 top sector", {27'd0, s_sect}, 32'h1F);
      t_ext(17'h05555, 8'h40);
      chk(s_v && s_op == 3'd4, "R6 boot lock", {29'd0, s_op}, 4);
      t_ext(17'h02AAA, 8'h10);
      chk(s_v == 1'b0, "R10 chip at wrong addr", {31'd0, s_v}, 0);
   endtask

   task automatic t_id();
      unlock("R7 prefix");
      wr(17'h05555, 16'h0090);
      chk(s_v && s_op == 3'd5, "R7 entry op", {29'd0, s_op}, 5);
      idle1();
      chk(id_mode == 1'b1, "R7 id_mode", {31'd0, id_mode}, 1);
      rd_addr = 17'd0; #1;
      chk(id_hit && id_data == 16'h001F, "R11 word0", {16'd0, id_data}, 32'h1F);
      rd_addr = 17'd1; #1;
      chk(id_hit && id_data == 16'h0082, "R11 word1", {16'd0, id_data}, 32'h82);
      rd_addr = 17'd2; #1;
      chk(!id_hit && id_data == 16'h0, "R11 other addr", {16'd0, id_data}, 0);
      unlock("R8 prefix");
      wr(17'h05555, 16'h00F0);
      chk(s_v && s_op == 3'd6, "R8 long exit op", {29'd0, s_op}, 6);
      idle1();
      chk(id_mode == 1'b0, "R8 long exit mode", {31'd0, id_mode}, 0);
      unlock("R7 prefix");
      wr(17'h05555, 16'h0090);
      idle1();
      chk(id_mode == 1'b1, "R7 re-entry", {31'd0, id_mode}, 1);
      wr(17'h0ABCD, 16'h00F0);
      chk(s_v && s_op == 3'd6, "R8 short exit op", {29'd0, s_op}, 6);
      idle1();
      chk(id_mode == 1'b0, "R8 short exit mode", {31'd0, id_mode}, 0);
      rd_addr = 17'd0; #1;
      chk(!id_hit && id_data == 16'h0, "R11 mode off", {31'd0, id_hit}, 0);
   endtask

   task automatic t_busy();
      wr(17'h05555, 16'h00AA); quiet("R9");
      busy = 1'b1;
      wr(17'h05555, 16'h0090); quiet("R9 busy write");
      wr(17'h0ABCD, 16'h00F0); quiet("R9 busy F0");
      busy = 1'b0;
      wr(17'h02AAA, 16'h0055); quiet("R9");
      wr(17'h05555, 16'h0090);
      chk(s_v && s_op == 3'd5, "R9 sequence resumed", {29'd0, s_op}, 5);
      wr(17'h00000, 16'h00F0);
      chk(s_v && s_op == 3'd6, "R9 cleanup exit", {29'd0, s_op}, 6);
   endtask

   task automatic t_mismatch();
      wr(17'h05555, 16'h00AA); quiet("R10");
      wr(17'h02AAB, 16'h0055); quiet("R10 wrong addr");
      wr(17'h05555, 16'h00A0); quiet("R10 no resume");
      wr(17'h00010, 16'h1234);
      chk(s_v == 1'b0, "R10 no program", {31'd0, s_v}, 0);
      unlock("R10");
      wr(17'h05555, 16'h0077); quiet("R10 bad code");
      wr(17'h00020, 16'h5678);
      chk(s_v == 1'b0, "R10 restart idle", {31'd0, s_v}, 0);
   endtask

   task automatic t_upper();
      wr(17'h05555, 16'hFFAA); quiet("R2");
      wr(17'h02AAA, 16'h3355); quiet("R2");
      wr(17'h05555, 16'hABA0); quiet("R2");
      wr(17'h00100, 16'hC0DE);
      chk(s_v && s_op == 3'd1 && s_data == 16'hC0DE, "R2 upper byte ignored",
          {16'd0, s_data}, 32'hC0DE);
   endtask

   initial begin
      t_reset();
      t_program();
      t_erase_lock();
      t_id();
      t_busy();
      t_mismatch();
      t_upper();
      rst = 1'b1; idle1(); rst = 1'b0;
      chk(cmd_valid == 1'b0 && id_mode == 1'b0, "R1 mid-run reset",
          {31'd0, id_mode}, 0);
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule